// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the programmer side of a four-wire serial programming link. It drives the target's reset line, the serial clock and the host-to-target data line, and it samples the target-to-host data line. On an enable request it holds the clock low, pulses reset high, waits a start-up interval and sends the enable frame. If the target's echo shows that the link is out of step, it repeats the whole attempt a bounded number of times.

Once the link is in step, a small command port runs word loads into the target's page buffer (low byte frame first, then high byte frame), page writes, single-byte EEPROM writes and byte reads. Each write is followed by a fixed quiet interval in place of busy polling. An end command releases reset so the target returns to normal operation. All frames are 32 bits, sent MSB first. Byte 0 is the opcode, bytes 1 and 2 carry the address zero-extended to 16 bits (high byte first), and byte 3 carries data.

Top module: `spgm_host`

## Requirements
- R1: After reset, tgt_rst, tgt_sck and tgt_mosi are 0, cmd_ready is 1, and sync_ok and sync_fail are 0.
- R2: An enable command (cmd_op 0) first drives tgt_rst high for at least RST_PULSE clocks while tgt_sck is low, then holds tgt_rst low for all serial activity.
- R3: At least STARTUP_CLKS clocks pass between tgt_rst falling and the first rising edge of tgt_sck.
- R4: The enable frame is bytes A5 53 00 00. All 32 bits are always sent, and sync_ok is set when the third byte returned on tgt_miso equals 0x53.
- R5: When the returned third byte is not 0x53, a new reset pulse, start-up wait and enable frame follow. A later matching echo sets sync_ok.
- R6: After MAX_TRIES mismatching attempts, sync_fail is 1, sync_ok is 0, tgt_rst stays low and tgt_sck stays low.
- R7: A word load (cmd_op 1) sends frame {0x41, addr, data[7:0]} and then frame {0x49, addr, data[15:8]}, in that order.
- R8: Each tgt_sck low and high phase lasts at least PH_CLKS clocks. tgt_mosi never changes while tgt_sck is high, and the returned bit is taken at the end of each high phase.
- R9: A page write (cmd_op 2) sends {0x4D, addr, 0x00} and is followed by at least FLASH_WAIT clocks without a tgt_sck edge. An EEPROM write (cmd_op 3) sends {0xC1, addr, data[7:0]} and is followed by at least EE_WAIT clocks without a tgt_sck edge.
- R10: A read (cmd_op 4) sends {0x21, addr, 0x00}. The fourth returned byte appears on rsp_data with a one-cycle rsp_valid.
- R11: Any command other than enable is ignored while the link is not in step: no tgt_sck edge and no rsp_valid follow.
- R12: An end command (cmd_op 5) drives tgt_rst high and clears sync_ok. tgt_rst then stays high with no tgt_sck activity until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when cmd_ready is high |
| cmd_op | input | 3 | 0 enable, 1 word load, 2 page write, 3 EEPROM write, 4 read, 5 end |
| cmd_addr | input | ADDR_W | Word, page or byte address |
| cmd_data | input | 16 | Word data for loads; low byte for EEPROM writes |
| cmd_ready | output | 1 | Sequencer can take a command |
| rsp_valid | output | 1 | One-cycle strobe carrying a read result |
| rsp_data | output | 8 | Byte returned by a read |
| sync_ok | output | 1 | Link is in step with the target |
| sync_fail | output | 1 | Enable gave up after MAX_TRIES attempts |
| tgt_rst | output | 1 | Target reset pin level |
| tgt_sck | output | 1 | Serial clock to target |
| tgt_mosi | output | 1 | Serial data to target |
| tgt_miso | input | 1 | Serial data from target |

## Verification
Enabling is tried against a target model that echoes at once, one that misses its echo twice before recovering, and one that never recovers. Together these separate a single attempt, retry with a fresh reset pulse, and give-up with its retry bound. Word loads use distinct low and high data bytes, so a swapped order or a wrong byte in either frame shows up. Page and EEPROM writes are each followed straight away by another command, which shows whether the quiet interval was kept. Reads at two addresses whose returned bytes differ check that the fourth byte is captured and not an echo of an earlier byte.

// File: rtl/spgm_pkg.sv
package spgm_pkg;

   localparam int FRAME_W = 32;

   typedef enum logic [2:0] {
      OP_ENABLE = 3'd0,
      OP_LOAD   = 3'd1,
      OP_PAGE   = 3'd2,
      OP_EEWR   = 3'd3,
      OP_READ   = 3'd4,
      OP_END    = 3'd5
   } op_e;

   localparam logic [7:0] OPC_ENA   = 8'hA5;
   localparam logic [7:0] SYNC_BYTE = 8'h53;
   localparam logic [7:0] OPC_LLO   = 8'h41;
   localparam logic [7:0] OPC_LHI   = 8'h49;
   localparam logic [7:0] OPC_PAGE  = 8'h4D;
   localparam logic [7:0] OPC_EEWR  = 8'hC1;
   localparam logic [7:0] OPC_READ  = 8'h21;

   function automatic logic [FRAME_W-1:0] mk_frame(input logic [7:0] opc,
                                                   input logic [15:0] adr,
                                                   input logic [7:0] dat);
      return {opc, adr, dat};
   endfunction

endpackage

// File: rtl/spgm_delay.sv
module spgm_delay #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] len,
   output logic         busy
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (start)        cnt <= len;
      else if (cnt != '0)    cnt <= cnt - W'(1);
   end

   assign busy = start | (cnt != '0);

   a_r9_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/spgm_shifter.sv
module spgm_shifter #(
   parameter int PH_CLKS     = 4,
   parameter int FRAME_W     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   input  logic               miso,
   output logic               busy,
   output logic               done,
   output logic               sck,
   output logic               mosi,
   output logic [15:0]        rx
);
   localparam int PH_W  = (PH_CLKS > 2) ? $clog2(PH_CLKS) : 1;
   localparam int BIT_W = $clog2(FRAME_W);

   logic               active;
   logic [PH_W-1:0]    ph;
   logic [BIT_W-1:0]   bidx;
   logic [FRAME_W-1:0] sh;
   logic               miso_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign miso_s = miso;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s1;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) s1 <= 1'b0;
            else        s1 <= miso;
         assign miso_s = s1;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[SYNC_STAGES-2:0], miso};
         assign miso_s = pipe[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         ph     <= '0;
         bidx   <= '0;
         sh     <= '0;
         sck    <= 1'b0;
         rx     <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               active <= 1'b1;
               sh     <= frame;
               ph     <= '0;
               bidx   <= '0;
               sck    <= 1'b0;
            end
         end else if (ph != PH_W'(PH_CLKS - 1)) begin
            ph <= ph + PH_W'(1);
         end else begin
            ph <= '0;
            if (!sck) begin
               sck <= 1'b1;
            end else begin
               sck <= 1'b0;
               rx  <= {rx[14:0], miso_s};
               if (bidx == BIT_W'(FRAME_W - 1)) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  bidx <= bidx + BIT_W'(1);
                  sh   <= {sh[FRAME_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign mosi = sh[FRAME_W-1];
   assign busy = active;

   a_r8_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(mosi));

endmodule

// File: rtl/spgm_host.sv
module spgm_host
   import spgm_pkg::*;
#(
   parameter int PH_CLKS      = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int ADDR_W       = 12,
   parameter int MAX_TRIES    = 3,
   parameter int RST_PULSE    = 8,
   parameter int STARTUP_CLKS = 320000,
   parameter int FLASH_WAIT   = 72000,
   parameter int EE_WAIT      = 144000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [15:0]       cmd_data,
   output logic              cmd_ready,
   output logic              rsp_valid,
   output logic [7:0]        rsp_data,
   output logic              sync_ok,
   output logic              sync_fail,
   output logic              tgt_rst,
   output logic              tgt_sck,
   output logic              tgt_mosi,
   input  logic              tgt_miso
);
   localparam int D_A    = (RST_PULSE > STARTUP_CLKS) ? RST_PULSE : STARTUP_CLKS;
   localparam int D_B    = (FLASH_WAIT > EE_WAIT) ? FLASH_WAIT : EE_WAIT;
   localparam int D_MAX  = (D_A > D_B) ? D_A : D_B;
   localparam int DLY_W  = $clog2(D_MAX + 1);
   localparam int TRY_W  = $clog2(MAX_TRIES + 1);

   generate
      if (PH_CLKS < 2) begin : g_bad_ph
         $error("PH_CLKS must be at least 2");
      end
      if (SYNC_STAGES >= PH_CLKS) begin : g_bad_sync
         $error("SYNC_STAGES must be below PH_CLKS");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must be 1 to 16");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
   endgenerate

   typedef enum logic [2:0] {
      S_IDLE, S_PULSE, S_STARTW, S_ENA, S_READY, S_XFER, S_HOLD, S_RUN
   } st_e;

   st_e                state;
   op_e                op;
   logic [15:0]        addr16;
   logic               rst_q, synced, failed;
   logic [TRY_W-1:0]   tries;
   logic               shf_start, shf_busy, shf_done;
   logic [FRAME_W-1:0] shf_frame, hi_frame;
   logic [15:0]        shf_rx;
   logic               dly_start, dly_busy;
   logic [DLY_W-1:0]   dly_len, post_len;
   logic               pend_hi, is_read;
   logic               rsp_v;
   logic [7:0]         rsp_q;

   assign op     = op_e'(cmd_op);
   assign addr16 = 16'(cmd_addr);

   spgm_shifter #(.PH_CLKS(PH_CLKS), .FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) shf_i (
      .clk(clk), .rst_n(rst_n), .start(shf_start), .frame(shf_frame), .miso(tgt_miso),
      .busy(shf_busy), .done(shf_done), .sck(tgt_sck), .mosi(tgt_mosi), .rx(shf_rx));

   spgm_delay #(.W(DLY_W)) dly_i (
      .clk(clk), .rst_n(rst_n), .start(dly_start), .len(dly_len), .busy(dly_busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         rst_q     <= 1'b0;
         tries     <= '0;
         synced    <= 1'b0;
         failed    <= 1'b0;
         shf_start <= 1'b0;
         shf_frame <= '0;
         hi_frame  <= '0;
         dly_start <= 1'b0;
         dly_len   <= '0;
         post_len  <= '0;
         pend_hi   <= 1'b0;
         is_read   <= 1'b0;
         rsp_v     <= 1'b0;
         rsp_q     <= '0;
      end else begin
         shf_start <= 1'b0;
         dly_start <= 1'b0;
         rsp_v     <= 1'b0;
         unique case (state)
            S_IDLE, S_READY, S_RUN: begin
               if (cmd_valid) begin
                  if (op == OP_ENABLE) begin
                     tries     <= '0;
                     synced    <= 1'b0;
                     failed    <= 1'b0;
                     rst_q     <= 1'b1;
                     dly_start <= 1'b1;
                     dly_len   <= DLY_W'(RST_PULSE);
                     state     <= S_PULSE;
                  end else if (state == S_READY) begin
                     pend_hi  <= 1'b0;
                     is_read  <= 1'b0;
                     post_len <= '0;
                     unique case (op)
                        OP_LOAD: begin
                           shf_frame <= mk_frame(OPC_LLO, addr16, cmd_data[7:0]);
                           hi_frame  <= mk_frame(OPC_LHI, addr16, cmd_data[15:8]);
                           pend_hi   <= 1'b1;
                           shf_start <= 1'b1;
                           state     <= S_XFER;
                        end
                        OP_PAGE: begin
                           shf_frame <= mk_frame(OPC_PAGE, addr16, 8'h00);
                           post_len  <= DLY_W'(FLASH_WAIT);
                           shf_start <= 1'b1;
                           state     <= S_XFER;
                        end
                        OP_EEWR: begin
                           shf_frame <= mk_frame(OPC_EEWR, addr16, cmd_data[7:0]);
                           post_len  <= DLY_W'(EE_WAIT);
                           shf_start <= 1'b1;
                           state     <= S_XFER;
                        end
                        OP_READ: begin
                           shf_frame <= mk_frame(OPC_READ, addr16, 8'h00);
                           is_read   <= 1'b1;
                           shf_start <= 1'b1;
                           state     <= S_XFER;
                        end
                        OP_END: begin
                           rst_q  <= 1'b1;
                           synced <= 1'b0;
                           state  <= S_RUN;
                        end
                        default: ;
                     endcase
                  end
               end
            end
            S_PULSE: begin
               if (!dly_busy) begin
                  rst_q     <= 1'b0;
                  dly_start <= 1'b1;
                  dly_len   <= DLY_W'(STARTUP_CLKS);
                  state     <= S_STARTW;
               end
            end
            S_STARTW: begin
               if (!dly_busy) begin
                  shf_frame <= mk_frame(OPC_ENA, {SYNC_BYTE, 8'h00}, 8'h00);
                  shf_start <= 1'b1;
                  state     <= S_ENA;
               end
            end
            S_ENA: begin
               if (shf_done) begin
                  if (shf_rx[15:8] == SYNC_BYTE) begin
                     synced <= 1'b1;
                     state  <= S_READY;
                  end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
                     failed <= 1'b1;
                     state  <= S_IDLE;
                  end else begin
                     tries     <= tries + TRY_W'(1);
                     rst_q     <= 1'b1;
                     dly_start <= 1'b1;
                     dly_len   <= DLY_W'(RST_PULSE);
                     state     <= S_PULSE;
                  end
               end
            end
            S_XFER: begin
               if (shf_done) begin
                  if (pend_hi) begin
                     pend_hi   <= 1'b0;
                     shf_frame <= hi_frame;
                     shf_start <= 1'b1;
                  end else if (is_read) begin
                     rsp_v <= 1'b1;
                     rsp_q <= shf_rx[7:0];
                     state <= S_READY;
                  end else if (post_len != '0) begin
                     dly_start <= 1'b1;
                     dly_len   <= post_len;
                     state     <= S_HOLD;
                  end else begin
                     state <= S_READY;
                  end
               end
            end
            S_HOLD: begin
               if (!dly_busy) state <= S_READY;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign cmd_ready = (state == S_IDLE) || (state == S_READY) || (state == S_RUN);
   assign rsp_valid = rsp_v;
   assign rsp_data  = rsp_q;
   assign sync_ok   = synced;
   assign sync_fail = failed;
   assign tgt_rst   = rst_q;

   a_r2_clock_only_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(tgt_sck) |-> !tgt_rst);
   a_r6_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sync_ok && sync_fail));
   a_r11_no_clock_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE || state == S_RUN) |-> (!tgt_sck && !shf_busy));
   a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_HOLD) |-> (!tgt_sck && $stable(tgt_mosi)));
   a_r3_startup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_STARTW) |-> (!tgt_rst && !tgt_sck));
   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      shf_start |-> !shf_busy);

endmodule

// File: tb/spgm_host_tb.sv
module spgm_host_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PH      = 4;
   localparam int RSTP    = 6;
   localparam int STARTUP = 300;
   localparam int FWAIT   = 400;
   localparam int EWAIT   = 250;
   localparam int TRIES   = 3;

   logic        clk = 0, rst_n = 0;
   logic        cmd_valid = 0;
   logic [2:0]  cmd_op = 0;
   logic [11:0] cmd_addr = 0;
   logic [15:0] cmd_data = 0;
   logic        cmd_ready, rsp_valid, sync_ok, sync_fail;
   logic [7:0]  rsp_data;
   logic        tgt_rst, tgt_sck, tgt_mosi, tgt_miso;

   always #(CLK_PERIOD/2) clk = ~clk;

   spgm_host #(.PH_CLKS(PH), .SYNC_STAGES(2), .ADDR_W(12), .MAX_TRIES(TRIES),
               .RST_PULSE(RSTP), .STARTUP_CLKS(STARTUP), .FLASH_WAIT(FWAIT),
               .EE_WAIT(EWAIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sync_ok(sync_ok),
      .sync_fail(sync_fail), .tgt_rst(tgt_rst), .tgt_sck(tgt_sck),
      .tgt_mosi(tgt_mosi), .tgt_miso(tgt_miso));

   // ---------------- target model ----------------
   logic [31:0] m_rx = 0;
   int          m_bits = 0;
   logic [7:0]  m_tx = 0;
   logic [31:0] flog [0:63];
   int          fcnt = 0;
   int          en_seen = 0;
   int          fail_until = 0;

   assign tgt_miso = m_tx[7];

   always @(posedge tgt_sck) begin
      m_rx   <= {m_rx[30:0], tgt_mosi};
      m_bits <= m_bits + 1;
   end

   always @(negedge tgt_sck) begin
      if (m_bits % 8 == 0) begin
         case ((m_bits / 8) % 4)
            1: m_tx <= m_rx[7:0];
            2: m_tx <= (en_seen < fail_until) ? 8'h00 : m_rx[7:0];
            3: m_tx <= (m_rx[23:16] == 8'h21) ? (8'h5A ^ m_rx[7:0]) : m_rx[7:0];
            default: begin
               if (fcnt < 64) flog[fcnt] <= m_rx;
               fcnt <= fcnt + 1;
               if (m_rx[31:24] == 8'hA5) en_seen <= en_seen + 1;
               m_tx <= 8'h00;
            end
         endcase
      end else begin
         m_tx <= {m_tx[6:0], 1'b0};
      end
   end

   // ---------------- pin monitor ----------------
   int pulses = 0, rises = 0, hi_run = 0, min_pulse = 1000000;
   int since_rst_fall = 0, startup_gap = 0, since_fall = 0, max_gap = 0;
   int lo_len = 0, hi_len = 0, min_lo = 1000000, min_hi = 1000000;
   int mosi_bad = 0, rsp_cnt = 0, epoch = 0, seen_epoch = 0;
   logic [7:0] rsp_last = 0;
   logic armed = 0, p_rst = 0, p_sck = 0, p_mosi = 0;

   always @(negedge clk) begin
      if (epoch != seen_epoch) begin seen_epoch = epoch; max_gap = 0; end
      if (tgt_rst && !p_rst) begin pulses++; hi_run = 0; end
      if (tgt_rst) hi_run++;
      if (!tgt_rst && p_rst) begin
         if (hi_run < min_pulse) min_pulse = hi_run;
         since_rst_fall = 0;
         armed = 1;
      end
      since_rst_fall++;
      since_fall++;
      if (tgt_sck && !p_sck) begin
         rises++;
         if (armed) begin startup_gap = since_rst_fall; armed = 0; end
         if (since_fall > max_gap) max_gap = since_fall;
         if (lo_len < min_lo) min_lo = lo_len;
         hi_len = 0;
      end
      if (!tgt_sck && p_sck) begin
         if (hi_len < min_hi) min_hi = hi_len;
         since_fall = 0;
         lo_len = 0;
      end
      if (tgt_sck) hi_len++; else lo_len++;
      if (tgt_sck && p_sck && (tgt_mosi != p_mosi)) mosi_bad++;
      if (rsp_valid) begin rsp_cnt++; rsp_last = rsp_data; end
      p_rst = tgt_rst; p_sck = tgt_sck; p_mosi = tgt_mosi;
   end

   // ---------------- checking ----------------
   int checks = 0, errors = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1;
      @(negedge clk);
      cmd_valid = 0;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      check(tgt_rst == 0,   "R1 tgt_rst",   tgt_rst, 0);
      check(tgt_sck == 0,   "R1 tgt_sck",   tgt_sck, 0);
      check(tgt_mosi == 0,  "R1 tgt_mosi",  tgt_mosi, 0);
      check(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
      check(sync_ok == 0 && sync_fail == 0, "R1 status", {sync_ok, sync_fail}, 0);
   endtask

   task automatic t_ignored(input string where);
      int r0, f0, s0;
      r0 = rises; f0 = fcnt; s0 = rsp_cnt;
      issue(3'd4, 12'h010, 16'h0);
      issue(3'd1, 12'h011, 16'h1234);
      repeat (200) @(negedge clk);
      check(rises == r0, {"R11 no clock ", where}, rises - r0, 0);
      check(fcnt == f0 && rsp_cnt == s0, {"R11 no frame/resp ", where},
            (fcnt - f0) + (rsp_cnt - s0), 0);
   endtask

   task automatic t_giveup;
      int p0, f0, r0;
      p0 = pulses; f0 = fcnt;
      fail_until = en_seen + TRIES;
      issue(3'd0, 12'h0, 16'h0);
      check(sync_fail == 1, "R6 sync_fail", sync_fail, 1);
      check(sync_ok == 0,   "R6 sync_ok",   sync_ok, 0);
      check(pulses - p0 == TRIES, "R6 attempts", pulses - p0, TRIES);
      check(fcnt - f0 == TRIES,   "R4 frames always complete", fcnt - f0, TRIES);
      r0 = rises;
      repeat (300) @(negedge clk);
      check(rises == r0 && tgt_rst == 0, "R6 idle after give-up", rises - r0, 0);
   endtask

   task automatic t_retry;
      int p0;
      p0 = pulses;
      fail_until = en_seen + 2;
      issue(3'd0, 12'h0, 16'h0);
      check(sync_ok == 1,   "R5 sync after retry", sync_ok, 1);
      check(sync_fail == 0, "R5 no failure flag",  sync_fail, 0);
      check(pulses - p0 == 3, "R5 reset pulses", pulses - p0, 3);
   endtask

   task automatic t_clean;
      int p0, f0;
      p0 = pulses; f0 = fcnt;
      fail_until = 0;
      issue(3'd0, 12'h0, 16'h0);
      check(sync_ok == 1, "R4 sync_ok", sync_ok, 1);
      check(pulses - p0 == 1, "R2 single pulse", pulses - p0, 1);
      check(min_pulse >= RSTP, "R2 pulse width", min_pulse, RSTP);
      check(startup_gap >= STARTUP, "R3 start-up wait", startup_gap, STARTUP);
      check(fcnt - f0 == 1 && flog[f0] == 32'hA5530000, "R4 enable frame", flog[f0], 32'hA5530000);
      check(tgt_rst == 0, "R2 reset held low", tgt_rst, 0);
   endtask

   task automatic t_load;
      int f0;
      f0 = fcnt;
      issue(3'd1, 12'h3A7, 16'hBEEF);
      check(fcnt - f0 == 2, "R7 two frames", fcnt - f0, 2);
      check(flog[f0] == 32'h4103A7EF, "R7 low byte frame first", flog[f0], 32'h4103A7EF);
      check(flog[f0+1] == 32'h4903A7BE, "R7 high byte frame second", flog[f0+1], 32'h4903A7BE);
   endtask

   task automatic t_page;
      int f0;
      f0 = fcnt;
      epoch++;
      issue(3'd2, 12'h0C0, 16'h0);
      issue(3'd4, 12'h000, 16'h0);
      check(flog[f0] == 32'h4D00C000, "R9 page frame", flog[f0], 32'h4D00C000);
      check(max_gap >= FWAIT, "R9 flash quiet time", max_gap, FWAIT);
   endtask

   task automatic t_ee;
      int f0;
      f0 = fcnt;
      epoch++;
      issue(3'd3, 12'h1F5, 16'h0066);
      issue(3'd4, 12'h000, 16'h0);
      check(flog[f0] == 32'hC101F566, "R9 eeprom frame", flog[f0], 32'hC101F566);
      check(max_gap >= EWAIT, "R9 eeprom quiet time", max_gap, EWAIT);
      check(max_gap < FWAIT, "R9 eeprom wait not flash wait", max_gap, EWAIT);
   endtask

   task automatic t_read(input logic [11:0] a);
      int s0, f0;
      s0 = rsp_cnt; f0 = fcnt;
      issue(3'd4, a, 16'h0);
      check(rsp_cnt - s0 == 1, "R10 one strobe", rsp_cnt - s0, 1);
      check(rsp_last == (8'h5A ^ a[7:0]), "R10 read byte", rsp_last, 8'h5A ^ a[7:0]);
      check(flog[f0] == {8'h21, 4'h0, a, 8'h00}, "R10 read frame", flog[f0], {8'h21, 4'h0, a, 8'h00});
   endtask

   task automatic t_timing;
      check(min_lo >= PH && min_hi >= PH, "R8 phase length", (min_lo < min_hi) ? min_lo : min_hi, PH);
      check(mosi_bad == 0, "R8 mosi quiet while sck high", mosi_bad, 0);
   endtask

   task automatic t_end;
      check(1'b1, "R12 pre", 0, 0);
      issue(3'd5, 12'h0, 16'h0);
      check(tgt_rst == 1, "R12 reset released", tgt_rst, 1);
      check(sync_ok == 0, "R12 sync cleared",   sync_ok, 0);
      t_ignored("after end");
      check(tgt_rst == 1, "R12 reset stays high", tgt_rst, 1);
   endtask

   initial begin : main
      bit timeout;
      timeout = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      fork
         begin
            t_reset();
            t_ignored("before enable");
            t_giveup();
            t_retry();
            t_clean();
            t_load();
            t_page();
            t_ee();
            t_read(12'h123);
            t_read(12'h0FE);
            t_timing();
            t_end();
         end
         begin
            repeat (150000) @(posedge clk);
            timeout = 1;
         end
      join_any
      disable fork;
      if (timeout) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule